// File: doc/BRIEF.md
# Disk Transfer Register Interface

This block is the processor-facing register file of a disk transfer engine. It decodes a 3-bit word offset on a 16-bit bus. It holds the following state:

- a mode register;
- a 24-bit transfer address assembled from three byte-wide registers;
- a byte counter that software loads as a number of 512-byte sectors.

At one offset the block either reaches through to the four registers of an attached floppy controller or exposes the sector counter. Which one it reaches depends on mode bits. Another offset returns a status word.

A transfer data path sits beside the block. That data path decrements the byte counter, flags overruns, and watches the direction reset pulse, which tells it to clear its received-byte count and buffer index. Two writes to the address registers carry into the next higher byte. This lets software step the address across a boundary by rewriting only the lower byte. Writing the opposite transfer direction into the mode register abandons whatever transfer is in progress.

Top module: `dsk_xfer_regs`

## Requirements
- R1: Offsets 0, 1 and 7 read as 0xFFFF. Writes to them change no state.
- R2: Offset 3 reads as status:
  - bits 15:3 are ones;
  - bit 0 is 1 while no overrun is recorded;
  - bit 1 is 1 while the byte counter is nonzero;
  - bit 2 follows `fdc_drq`.
- R3: With mode bit 4 set, a write to offset 2 loads the byte counter with data[7:0] × 512. A read of offset 2 returns the counter divided by 512, rounded up, in bits 8:0 with the upper bits zero. Each cycle that `xfer_dec` is high, a nonzero counter drops by one.
- R4: With mode bits 4 and 3 clear, an offset-2 write pulses `fdc_wr` with data[7:0] on `fdc_wdata`. An offset-2 read returns 0xFF above `fdc_rdata`. `fdc_addr` always equals mode bits 2:1.
- R5: With mode bit 3 set and bit 4 clear, offset 2 reads as 0xFFFF and a write there gives no `fdc_wr` pulse.
- R6: Offsets 4, 5 and 6 read address bits 23:16, 15:8 and 7:0 under an upper byte of 0xFF. A write to offset 6 stores data bit 0 as 0.
- R7: A write to offset 5 whose data bit 7 is 0, while address bit 15 is 1, first adds 0x10000 to the address (wrapping at 24 bits), then replaces bits 15:8.
- R8: A write to offset 6 whose data bit 7 is 0, while address bit 7 is 1, first adds 0x100 to the address, then replaces bits 7:0.
- R9: An offset-3 write that flips mode bit 8 clears the byte counter and the overrun flag, and pulses `dir_reset` in that cycle. A mode write that keeps bit 8 does neither.
- R10: After synchronous reset, every register is zero: the address is 0, the counter is 0, no overrun is recorded and the mode bits are clear.
- R11: `xfer_err` sets the overrun flag. `xfer_dir` shows mode bit 8 and `drq_from_fdc` shows mode bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_off | input | 3 | Word offset of the access |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from state |
| fdc_addr | output | 2 | Floppy controller register select |
| fdc_wr | output | 1 | Floppy controller write strobe |
| fdc_wdata | output | 8 | Floppy controller write data |
| fdc_rdata | input | 8 | Floppy controller read data |
| fdc_drq | input | 1 | Floppy controller data request |
| xfer_dec | input | 1 | Data path consumed one byte |
| xfer_err | input | 1 | Data path overrun |
| xfer_dir | output | 1 | Transfer direction, 1 = toward the disk |
| drq_from_fdc | output | 1 | Floppy controller chosen as request source |
| dir_reset | output | 1 | Direction change, clear data path state |
| dma_addr | output | 24 | Transfer address |

## Verification
The carry cases are the hardest to reach. Each needs the address byte's top bit already set from an earlier write, followed by a write whose bit 7 is clear. The stimulus therefore writes 0xFF and 0x80 patterns first, and then rewrites with low values. The top-byte wrap is reached by first loading 0xFF into the high byte. The rounding of the sector readback is reached by driving `xfer_dec` exactly once and then exactly 512 more times, which leaves the counter just below a sector multiple.

// File: rtl/dsk_xfer_regs.sv
module dsk_xfer_regs #(
  parameter int SECT_W     = 8,
  parameter int SECT_SHIFT = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_off,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [1:0]  fdc_addr,
  output logic        fdc_wr,
  output logic [7:0]  fdc_wdata,
  input  logic [7:0]  fdc_rdata,
  input  logic        fdc_drq,
  input  logic        xfer_dec,
  input  logic        xfer_err,
  output logic        xfer_dir,
  output logic        drq_from_fdc,
  output logic        dir_reset,
  output logic [23:0] dma_addr
);
  localparam int BC_W  = SECT_W + SECT_SHIFT;
  localparam int SR_W  = SECT_W + 1;
  localparam logic [BC_W:0] ROUND = (BC_W+1)'((1 << SECT_SHIFT) - 1);

  logic [8:0]      mode;
  logic [23:0]     addr;
  logic [BC_W-1:0] bcnt;
  logic            err;

  logic sel_cnt, sel_hd;
  assign sel_cnt = mode[4];
  assign sel_hd  = mode[3];

  logic wr_mode, wr_cnt;
  assign wr_mode   = reg_wr && reg_off == 3'd3;
  assign wr_cnt    = reg_wr && reg_off == 3'd2 && sel_cnt;
  assign dir_reset = wr_mode && (reg_wdata[8] != mode[8]);

  assign fdc_addr  = mode[2:1];
  assign fdc_wdata = reg_wdata[7:0];
  assign fdc_wr    = reg_wr && reg_off == 3'd2 && !sel_cnt && !sel_hd;

  assign xfer_dir     = mode[8];
  assign drq_from_fdc = mode[7];
  assign dma_addr     = addr;

  logic [23:0] addr_c5, addr_c6;
  assign addr_c5 = addr + ((addr[15] && !reg_wdata[7]) ? 24'h010000 : 24'h0);
  assign addr_c6 = addr + ((addr[7]  && !reg_wdata[7]) ? 24'h000100 : 24'h0);

  logic [BC_W:0] bc_round;
  logic [SR_W-1:0] sect_rd;
  assign bc_round = {1'b0, bcnt} + ROUND;
  assign sect_rd  = bc_round[BC_W:SECT_SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      addr <= '0;
      bcnt <= '0;
      err  <= 1'b0;
    end else begin
      if (dir_reset) err <= 1'b0;
      else if (xfer_err) err <= 1'b1;

      if (dir_reset) bcnt <= '0;
      else if (wr_cnt) bcnt <= {reg_wdata[SECT_W-1:0], {SECT_SHIFT{1'b0}}};
      else if (xfer_dec && bcnt != '0) bcnt <= bcnt - 1'b1;

      if (wr_mode) mode <= reg_wdata[8:0];

      if (reg_wr) begin
        case (reg_off)
          3'd4: addr <= {reg_wdata[7:0], addr[15:0]};
          3'd5: addr <= {addr_c5[23:16], reg_wdata[7:0], addr_c5[7:0]};
          3'd6: addr <= {addr_c6[23:8], reg_wdata[7:1], 1'b0};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_off)
      3'd2: begin
        if (sel_cnt)     reg_rdata = {{(16-SR_W){1'b0}}, sect_rd};
        else if (sel_hd) reg_rdata = 16'hFFFF;
        else             reg_rdata = {8'hFF, fdc_rdata};
      end
      3'd3: reg_rdata = {13'h1FFF, fdc_drq, bcnt != '0, !err};
      3'd4: reg_rdata = {8'hFF, addr[23:16]};
      3'd5: reg_rdata = {8'hFF, addr[15:8]};
      3'd6: reg_rdata = {8'hFF, addr[7:0]};
      default: reg_rdata = 16'hFFFF;
    endcase
  end
endmodule

// File: rtl/dsk_xfer_regs_chk.sv
module dsk_xfer_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  reg_off,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        fdc_wr,
  input logic        xfer_dir,
  input logic        dir_reset,
  input logic [23:0] dma_addr,
  input logic [8:0]  mode
);
  a_r1_reserved_ones: assert property (@(posedge clk) disable iff (rst)
    (reg_off == 3'd0 || reg_off == 3'd1 || reg_off == 3'd7) |-> reg_rdata == 16'hFFFF);

  a_r2_status_top: assert property (@(posedge clk) disable iff (rst)
    reg_off == 3'd3 |-> reg_rdata[15:3] == 13'h1FFF);

  a_r5_hd_no_strobe: assert property (@(posedge clk) disable iff (rst)
    fdc_wr |-> (!mode[3] && !mode[4]));

  a_r6_low_bit_zero: assert property (@(posedge clk) disable iff (rst)
    !dma_addr[0]);

  a_r8_low_carry: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_off == 3'd6 && dma_addr[7] && !reg_wdata[7])
      |=> dma_addr[15:8] == $past(dma_addr[15:8]) + 8'd1);

  a_r7_mid_carry: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_off == 3'd5 && dma_addr[15] && !reg_wdata[7])
      |=> dma_addr[23:16] == $past(dma_addr[23:16]) + 8'd1);

  a_r9_dir_flips: assert property (@(posedge clk) disable iff (rst)
    dir_reset |=> xfer_dir != $past(xfer_dir));
endmodule

bind dsk_xfer_regs dsk_xfer_regs_chk chk_i (
  .clk(clk), .rst(rst), .reg_off(reg_off), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fdc_wr(fdc_wr),
  .xfer_dir(xfer_dir), .dir_reset(dir_reset), .dma_addr(dma_addr),
  .mode(mode)
);

// File: tb/dsk_xfer_regs_tb_top.sv
module dsk_xfer_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_off = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  fdc_addr;
  logic        fdc_wr;
  logic [7:0]  fdc_wdata;
  logic [7:0]  fdc_rdata;
  logic        fdc_drq = 1'b0;
  logic        xfer_dec = 1'b0;
  logic        xfer_err = 1'b0;
  logic        xfer_dir, drq_from_fdc, dir_reset;
  logic [23:0] dma_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign fdc_rdata = 8'h10 + {6'd0, fdc_addr};

  dsk_xfer_regs dut_i (
    .clk(clk), .rst(rst), .reg_off(reg_off), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fdc_addr(fdc_addr),
    .fdc_wr(fdc_wr), .fdc_wdata(fdc_wdata), .fdc_rdata(fdc_rdata),
    .fdc_drq(fdc_drq), .xfer_dec(xfer_dec), .xfer_err(xfer_err),
    .xfer_dir(xfer_dir), .drq_from_fdc(drq_from_fdc),
    .dir_reset(dir_reset), .dma_addr(dma_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [15:0] d);
    @(negedge clk);
    reg_off = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] off, input logic [15:0] exp);
    @(negedge clk);
    reg_off = off; reg_wr = 1'b0;
    #1 check(req, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  // {is_write(4), offset(4), data(16), expected(16)}
  localparam int NV = 33;
  localparam logic [39:0] VEC [NV] = '{
    {4'h0, 4'h0, 16'h0000, 16'hFFFF},  // R1
    {4'h0, 4'h7, 16'h0000, 16'hFFFF},  // R1
    {4'h0, 4'h3, 16'h0000, 16'hFFF9},  // R2
    {4'h1, 4'h3, 16'h0006, 16'h0000},
    {4'h0, 4'h2, 16'h0000, 16'hFF13},  // R4
    {4'h1, 4'h3, 16'h0010, 16'h0000},
    {4'h1, 4'h2, 16'h0005, 16'h0000},
    {4'h0, 4'h2, 16'h0000, 16'h0005},  // R3
    {4'h0, 4'h3, 16'h0000, 16'hFFFB},  // R2
    {4'h1, 4'h4, 16'h0012, 16'h0000},
    {4'h0, 4'h4, 16'h0000, 16'hFF12},  // R6
    {4'h1, 4'h5, 16'h0080, 16'h0000},
    {4'h1, 4'h6, 16'h00FF, 16'h0000},
    {4'h0, 4'h6, 16'h0000, 16'hFFFE},  // R6 low bit
    {4'h1, 4'h6, 16'h0010, 16'h0000},
    {4'h0, 4'h5, 16'h0000, 16'hFF81},  // R8
    {4'h0, 4'h6, 16'h0000, 16'hFF10},  // R8
    {4'h1, 4'h5, 16'h0001, 16'h0000},
    {4'h0, 4'h4, 16'h0000, 16'hFF13},  // R7
    {4'h0, 4'h5, 16'h0000, 16'hFF01},  // R7
    {4'h1, 4'h0, 16'hFFFF, 16'h0000},
    {4'h1, 4'h1, 16'hFFFF, 16'h0000},
    {4'h1, 4'h7, 16'hFFFF, 16'h0000},
    {4'h0, 4'h4, 16'h0000, 16'hFF13},  // R1 writes ignored
    {4'h0, 4'h2, 16'h0000, 16'h0005},  // R1 writes ignored
    {4'h1, 4'h4, 16'h00FF, 16'h0000},
    {4'h1, 4'h5, 16'h0080, 16'h0000},
    {4'h1, 4'h5, 16'h0000, 16'h0000},
    {4'h0, 4'h4, 16'h0000, 16'hFF00},  // R7 wrap
    {4'h1, 4'h6, 16'h0090, 16'h0000},
    {4'h1, 4'h6, 16'h0020, 16'h0000},
    {4'h0, 4'h5, 16'h0000, 16'hFF01},  // R8 carry from 0x90
    {4'h0, 4'h6, 16'h0000, 16'hFF20}   // R8
  };

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 addr", {8'd0, dma_addr}, 32'd0);
    check("R10 dir", {31'd0, xfer_dir}, 32'd0);
    rst = 1'b0;
    rd("R10 status", 3'd3, 16'hFFF9);
    rd("R10 count", 3'd2, 16'hFF10);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][39:36] != 4'h0) wr(VEC[i][34:32], VEC[i][31:16]);
      else rd($sformatf("R1-6 vec %0d", i), VEC[i][34:32], VEC[i][15:0]);
    end

    // R4 floppy write strobe
    wr(3'd3, 16'h0004);
    @(negedge clk);
    reg_off = 3'd2; reg_wdata = 16'h12AB; reg_wr = 1'b1;
    #1 check("R4 fdc_wr", {31'd0, fdc_wr}, 32'd1);
    check("R4 fdc_wdata", {24'd0, fdc_wdata}, 32'hAB);
    check("R4 fdc_addr", {30'd0, fdc_addr}, 32'd2);
    @(negedge clk); reg_wr = 1'b0;

    // R5 hard-disk path
    wr(3'd3, 16'h0008);
    rd("R5 read", 3'd2, 16'hFFFF);
    @(negedge clk);
    reg_off = 3'd2; reg_wdata = 16'h1234; reg_wr = 1'b1;
    #1 check("R5 no strobe", {31'd0, fdc_wr}, 32'd0);
    @(negedge clk); reg_wr = 1'b0;

    // R11 outputs and error, R2 drq
    wr(3'd3, 16'h0090);
    #1 check("R11 drq sel", {31'd0, drq_from_fdc}, 32'd1);
    check("R11 dir", {31'd0, xfer_dir}, 32'd0);
    @(negedge clk); xfer_err = 1'b1; fdc_drq = 1'b1;
    @(negedge clk); xfer_err = 1'b0;
    rd("R11 R2 err+drq", 3'd3, 16'hFFFE);
    fdc_drq = 1'b0;

    // R3 decrement and rounding
    wr(3'd2, 16'h0002);
    @(negedge clk); xfer_dec = 1'b1;
    @(negedge clk); xfer_dec = 1'b0;
    rd("R3 one dec", 3'd2, 16'h0002);
    @(negedge clk); xfer_dec = 1'b1;
    repeat (512) @(negedge clk);
    xfer_dec = 1'b0;
    rd("R3 513 dec", 3'd2, 16'h0001);

    // R9 same direction keeps state
    wr(3'd3, 16'h0010);
    rd("R9 no flip", 3'd2, 16'h0001);
    // R9 flip clears
    @(negedge clk);
    reg_off = 3'd3; reg_wdata = 16'h0110; reg_wr = 1'b1;
    #1 check("R9 pulse", {31'd0, dir_reset}, 32'd1);
    @(negedge clk); reg_wr = 1'b0;
    #1 check("R9 pulse gone", {31'd0, dir_reset}, 32'd0);
    check("R11 dir set", {31'd0, xfer_dir}, 32'd1);
    rd("R9 count cleared", 3'd2, 16'h0000);
    rd("R9 err cleared", 3'd3, 16'hFFF9);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule